// File: doc/BRIEF.md
# Programmable PLA Mealy Sequencer Logic

This block is the combinational core of a field-configurable Mealy state machine. A programmable AND plane builds 64 product terms. Each term can test the true or complement form of any of 16 external input bits, of 8 bits fed back from the state register, and of two complement signals. A programmable OR plane then connects any term to the J input, the K input, or both, of any of 16 flip-flops: 8 state bits and 8 output bits. The flip-flops sit outside the block. It delivers only their J/K vectors, so that each bit can be set, reset, toggled or held.

There are two complement arrays. Each one ORs a chosen group of product terms and inverts the result. The inverted value is fed back into the AND plane as one more variable. A single term can then mean "none of these other conditions holds". That covers the else branch of an if-then-else, or the recovery from an illegal state.

The configuration is written one field of one term at a time through a clocked load port and kept in internal registers. Two kinds of image are refused, and an error flag is raised instead. The first has a term that drives a complement array and also tests a complement signal. The second has a term that would toggle more registers than the allowed limit. Evaluation from inputs and present state to J/K vectors has no register on the path.

Top module: `pla_mealy_seq`

## Requirements
- R1: After reset the image is blank: every literal code is 00, every J/K connection is open and no term feeds a complement array. In this state all four J/K output vectors are 0 for any input and state, and cfg_err is 0.
- R2: For a term, variable v has its 2-bit literal code at cfg_data[2v+1:2v] of a write with cfg_field=0. Variables are numbered as follows: in_bits[0..15] are 0..15, state_q[0..7] are 16..23, complement signal C0 is 24 and C1 is 25. The codes are 00 (inactive), 01 (variable must be 1), 10 (variable must be 0) and 11 (don't care). A term is 1 only when every one of its literals passes. Any literal at 00 forces the term to 0.
- R3: A write with cfg_field=1 sets a term's J connections and cfg_field=2 sets its K connections, using cfg_data[15:0]. Bits 0..7 are state registers 0..7 (st_j/st_k) and bits 8..15 are output registers 0..7 (out_j/out_k). Each J/K output is the OR of the active terms connected to it, and is 0 when none are.
- R4: One active term connected to both J and K of a register drives both high (toggle). A register with no active connection sees J=K=0 (hold).
- R5: A write with cfg_field=3 sets which complement arrays a term feeds: cfg_data[0] selects C0 and cfg_data[1] selects C1. A complement signal is 1 exactly when none of the terms feeding it is active.
- R6: A write is refused when the term it leaves would both feed a complement array and carry code 01 or 10 on C0 or C1. A refused write sets cfg_err and leaves the image unchanged.
- R7: A write is refused in the same way when the term it leaves would be connected to both J and K of more than TOG_MAX (default 8) registers. Exactly TOG_MAX is accepted.
- R8: cfg_err is updated only by a write: it becomes 1 for a refused write and 0 for an accepted one, and keeps its value in cycles without a write.
- R9: The J/K outputs follow in_bits and state_q with no clock edge in between. A configuration write takes effect from the clock edge that accepts it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Active-low asynchronous reset to a blank image |
| cfg_wr | input | 1 | Write strobe for one configuration field |
| cfg_term | input | 6 | Product term addressed by the write |
| cfg_field | input | 2 | Field selector: 0 literals, 1 J, 2 K, 3 complement feed |
| cfg_data | input | 52 | Field contents, low bits used for narrow fields |
| cfg_err | output | 1 | Last write was refused |
| in_bits | input | 16 | External logic inputs |
| state_q | input | 8 | Present state fed back from the state register |
| st_j | output | 8 | J inputs of the state register bits |
| st_k | output | 8 | K inputs of the state register bits |
| out_j | output | 8 | J inputs of the output register bits |
| out_k | output | 8 | K inputs of the output register bits |

## Verification
The hardest case to reach is a refused write that is visible at the ports. A bad image would only change behaviour through the complement feedback, and only under particular inputs. The stimulus first builds two complement arrays whose behaviour is known and confirms them over every combination of the three inputs involved. It then tries to add a forbidden feedback coupling. After the refused write it applies an input pattern that yields a different output value depending on whether the coupling went in or not. The toggle limit is approached in the same way, stepping from exactly TOG_MAX toggled registers to one more.

// File: rtl/pla_seq_pkg.sv
package pla_seq_pkg;

   typedef enum logic [1:0] {
      FLD_AND  = 2'd0,
      FLD_JSET = 2'd1,
      FLD_KSET = 2'd2,
      FLD_FEED = 2'd3
   } cfg_field_e;

   localparam logic [1:0] LIT_OFF = 2'b00;
   localparam logic [1:0] LIT_POS = 2'b01;
   localparam logic [1:0] LIT_NEG = 2'b10;

   // literal passes: bit0 admits a 1, bit1 admits a 0
   function automatic logic lit_pass(input logic [1:0] code, input logic v);
      return (code[0] & v) | (code[1] & ~v);
   endfunction

   // literal actually tests its variable (true or complement form)
   function automatic logic lit_used(input logic [1:0] code);
      return (code == LIT_POS) || (code == LIT_NEG);
   endfunction

endpackage

// File: rtl/pla_cfg_store.sv
module pla_cfg_store
   import pla_seq_pkg::*;
#(
   parameter int N_IN    = 16,
   parameter int N_ST    = 8,
   parameter int N_OUT   = 8,
   parameter int N_TERM  = 64,
   parameter int N_CMP   = 2,
   parameter int TOG_MAX = 8,
   localparam int N_VAR   = N_IN + N_ST + N_CMP,
   localparam int LIT_W   = 2 * N_VAR,
   localparam int N_REG   = N_ST + N_OUT,
   localparam int TERM_AW = $clog2(N_TERM),
   localparam int CFG_W   = LIT_W
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             cfg_wr,
   input  logic [TERM_AW-1:0]               cfg_term,
   input  logic [1:0]                       cfg_field,
   input  logic [CFG_W-1:0]                 cfg_data,
   output logic [N_TERM-1:0][LIT_W-1:0]     lits_o,
   output logic [N_TERM-1:0][N_REG-1:0]     jrow_o,
   output logic [N_TERM-1:0][N_REG-1:0]     krow_o,
   output logic [N_TERM-1:0][N_CMP-1:0]     feed_o,
   output logic                             err_o
);

   localparam int CMP_BASE = N_IN + N_ST;

   logic [N_TERM-1:0][LIT_W-1:0] lits_q;
   logic [N_TERM-1:0][N_REG-1:0] jrow_q;
   logic [N_TERM-1:0][N_REG-1:0] krow_q;
   logic [N_TERM-1:0][N_CMP-1:0] feed_q;
   logic                         err_q;

   cfg_field_e       fld;
   logic [LIT_W-1:0] nl;
   logic [N_REG-1:0] nj;
   logic [N_REG-1:0] nk;
   logic [N_CMP-1:0] nf;
   logic             c_use;
   logic             loop_bad;
   logic             tog_bad;
   int               tog_cnt;

   assign fld = cfg_field_e'(cfg_field);

   // candidate contents of the addressed term after this write
   always_comb begin
      nl = lits_q[cfg_term];
      nj = jrow_q[cfg_term];
      nk = krow_q[cfg_term];
      nf = feed_q[cfg_term];
      unique case (fld)
         FLD_AND:  nl = cfg_data[LIT_W-1:0];
         FLD_JSET: nj = cfg_data[N_REG-1:0];
         FLD_KSET: nk = cfg_data[N_REG-1:0];
         FLD_FEED: nf = cfg_data[N_CMP-1:0];
         default:  nl = lits_q[cfg_term];
      endcase
   end

   // legality of the candidate term
   always_comb begin
      c_use = 1'b0;
      for (int c = 0; c < N_CMP; c++) begin
         c_use = c_use | lit_used(nl[2*(CMP_BASE+c) +: 2]);
      end
      tog_cnt = 0;
      for (int r = 0; r < N_REG; r++) begin
         if (nj[r] && nk[r]) tog_cnt = tog_cnt + 1;
      end
      loop_bad = c_use & (|nf);
      tog_bad  = (tog_cnt > TOG_MAX);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lits_q <= '0;
         jrow_q <= '0;
         krow_q <= '0;
         feed_q <= '0;
         err_q  <= 1'b0;
      end else if (cfg_wr) begin
         err_q <= loop_bad | tog_bad;
         if (!(loop_bad | tog_bad)) begin
            lits_q[cfg_term] <= nl;
            jrow_q[cfg_term] <= nj;
            krow_q[cfg_term] <= nk;
            feed_q[cfg_term] <= nf;
         end
      end
   end

   assign lits_o = lits_q;
   assign jrow_o = jrow_q;
   assign krow_o = krow_q;
   assign feed_o = feed_q;
   assign err_o  = err_q;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
   import pla_seq_pkg::*;
#(
   parameter int N_IN   = 16,
   parameter int N_ST   = 8,
   parameter int N_TERM = 64,
   parameter int N_CMP  = 2,
   localparam int N_VAR = N_IN + N_ST + N_CMP,
   localparam int LIT_W = 2 * N_VAR,
   localparam int N_X   = N_IN + N_ST
) (
   input  logic [N_TERM-1:0][LIT_W-1:0] lits,
   input  logic [N_TERM-1:0][N_CMP-1:0] feed,
   input  logic [N_IN-1:0]              in_bits,
   input  logic [N_ST-1:0]              state_q,
   output logic [N_TERM-1:0]            term_o
);

   logic [N_X-1:0]    xv;
   logic [N_TERM-1:0] p_base;
   logic [N_TERM-1:0] c_ok;
   logic [N_CMP-1:0]  cmp;

   assign xv = {state_q, in_bits};

   // first pass: inputs and state only
   for (genvar t = 0; t < N_TERM; t++) begin : g_base
      logic pb;
      logic ok;
      always_comb begin
         pb = 1'b1;
         for (int v = 0; v < N_X; v++) begin
            pb = pb & lit_pass(lits[t][2*v +: 2], xv[v]);
         end
         ok = 1'b1;
         for (int c = 0; c < N_CMP; c++) begin
            ok = ok & (lits[t][2*(N_X+c) +: 2] != LIT_OFF);
         end
      end
      assign p_base[t] = pb;
      assign c_ok[t]   = ok;
   end

   // complement arrays: inverted OR of the feeding terms
   for (genvar c = 0; c < N_CMP; c++) begin : g_cmp
      logic hit;
      always_comb begin
         hit = 1'b0;
         for (int t = 0; t < N_TERM; t++) begin
            hit = hit | (feed[t][c] & p_base[t] & c_ok[t]);
         end
      end
      assign cmp[c] = ~hit;
   end

   // second pass: apply complement literals
   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic tv;
      always_comb begin
         tv = p_base[t];
         for (int c = 0; c < N_CMP; c++) begin
            tv = tv & lit_pass(lits[t][2*(N_X+c) +: 2], cmp[c]);
         end
      end
      assign term_o[t] = tv;
   end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 64,
   parameter int N_REG  = 16
) (
   input  logic [N_TERM-1:0]            term,
   input  logic [N_TERM-1:0][N_REG-1:0] jrow,
   input  logic [N_TERM-1:0][N_REG-1:0] krow,
   output logic [N_REG-1:0]             j_o,
   output logic [N_REG-1:0]             k_o
);

   for (genvar r = 0; r < N_REG; r++) begin : g_reg
      logic aj;
      logic ak;
      always_comb begin
         aj = 1'b0;
         ak = 1'b0;
         for (int t = 0; t < N_TERM; t++) begin
            aj = aj | (term[t] & jrow[t][r]);
            ak = ak | (term[t] & krow[t][r]);
         end
      end
      assign j_o[r] = aj;
      assign k_o[r] = ak;
   end

endmodule

// File: rtl/pla_mealy_seq.sv
module pla_mealy_seq #(
   parameter int N_IN    = 16,
   parameter int N_ST    = 8,
   parameter int N_OUT   = 8,
   parameter int N_TERM  = 64,
   parameter int N_CMP   = 2,
   parameter int TOG_MAX = 8,
   localparam int N_VAR   = N_IN + N_ST + N_CMP,
   localparam int LIT_W   = 2 * N_VAR,
   localparam int N_REG   = N_ST + N_OUT,
   localparam int TERM_AW = $clog2(N_TERM),
   localparam int CFG_W   = LIT_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic [TERM_AW-1:0] cfg_term,
   input  logic [1:0]         cfg_field,
   input  logic [CFG_W-1:0]   cfg_data,
   output logic               cfg_err,
   input  logic [N_IN-1:0]    in_bits,
   input  logic [N_ST-1:0]    state_q,
   output logic [N_ST-1:0]    st_j,
   output logic [N_ST-1:0]    st_k,
   output logic [N_OUT-1:0]   out_j,
   output logic [N_OUT-1:0]   out_k
);

   logic [N_TERM-1:0][LIT_W-1:0] lits;
   logic [N_TERM-1:0][N_REG-1:0] jrow;
   logic [N_TERM-1:0][N_REG-1:0] krow;
   logic [N_TERM-1:0][N_CMP-1:0] feed;
   logic [N_TERM-1:0]            term;
   logic [N_REG-1:0]             j_all;
   logic [N_REG-1:0]             k_all;

   pla_cfg_store #(
      .N_IN(N_IN), .N_ST(N_ST), .N_OUT(N_OUT),
      .N_TERM(N_TERM), .N_CMP(N_CMP), .TOG_MAX(TOG_MAX)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr),
      .cfg_term (cfg_term),
      .cfg_field(cfg_field),
      .cfg_data (cfg_data),
      .lits_o   (lits),
      .jrow_o   (jrow),
      .krow_o   (krow),
      .feed_o   (feed),
      .err_o    (cfg_err)
   );

   pla_and_plane #(
      .N_IN(N_IN), .N_ST(N_ST), .N_TERM(N_TERM), .N_CMP(N_CMP)
   ) u_and (
      .lits   (lits),
      .feed   (feed),
      .in_bits(in_bits),
      .state_q(state_q),
      .term_o (term)
   );

   pla_or_plane #(
      .N_TERM(N_TERM), .N_REG(N_REG)
   ) u_or (
      .term(term),
      .jrow(jrow),
      .krow(krow),
      .j_o (j_all),
      .k_o (k_all)
   );

   assign st_j  = j_all[N_ST-1:0];
   assign st_k  = k_all[N_ST-1:0];
   assign out_j = j_all[N_REG-1:N_ST];
   assign out_k = k_all[N_REG-1:N_ST];

endmodule

// File: rtl/pla_mealy_seq_chk.sv
module pla_mealy_seq_chk
   import pla_seq_pkg::*;
#(
   parameter int N_IN    = 16,
   parameter int N_ST    = 8,
   parameter int N_OUT   = 8,
   parameter int N_TERM  = 64,
   parameter int N_CMP   = 2,
   parameter int TOG_MAX = 8,
   localparam int N_VAR  = N_IN + N_ST + N_CMP,
   localparam int LIT_W  = 2 * N_VAR,
   localparam int N_REG  = N_ST + N_OUT
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         cfg_wr,
   input logic                         cfg_err,
   input logic [N_ST-1:0]              st_j,
   input logic [N_ST-1:0]              st_k,
   input logic [N_OUT-1:0]             out_j,
   input logic [N_OUT-1:0]             out_k,
   input logic [N_TERM-1:0][LIT_W-1:0] lits,
   input logic [N_TERM-1:0][N_REG-1:0] jrow,
   input logic [N_TERM-1:0][N_REG-1:0] krow,
   input logic [N_TERM-1:0][N_CMP-1:0] feed,
   input logic [N_TERM-1:0]            term
);

   localparam int CMP_BASE = N_IN + N_ST;

   // elaboration-time parameter checks
   initial begin
      a_r2_fits_port: assert (LIT_W >= N_REG && LIT_W >= N_CMP);
      a_r2_term_pow2: assert (N_TERM == (1 << $clog2(N_TERM)) && N_TERM > 1);
      a_r7_tog_range: assert (TOG_MAX >= 1 && TOG_MAX <= N_REG);
   end

   logic touched;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      touched <= 1'b0;
      else if (cfg_wr) touched <= 1'b1;
   end

   // R1: blank image leaves every J/K output low
   a_r1_blank_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !touched |-> ({st_j, st_k, out_j, out_k} == '0));

   // R3: with no active term the OR plane drives nothing
   a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (term == '0) |-> ({st_j, st_k, out_j, out_k} == '0));

   // R8: flag moves only on a write
   a_r8_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_wr) |-> $stable(cfg_err));

   // R6: a refused write leaves the image as it was
   a_r6_refused_stable: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cfg_wr) && cfg_err) |->
         ($stable(lits) && $stable(jrow) && $stable(krow) && $stable(feed)));

   for (genvar t = 0; t < N_TERM; t++) begin : g_t
      logic cu;
      always_comb begin
         cu = 1'b0;
         for (int c = 0; c < N_CMP; c++) begin
            cu = cu | lit_used(lits[t][2*(CMP_BASE+c) +: 2]);
         end
      end
      // R6: no stored term both feeds an array and tests a complement
      a_r6_no_loop: assert property (@(posedge clk) disable iff (!rst_n)
         !(cu && (|feed[t])));
      // R7: stored toggle fan-out within limit
      a_r7_tog_limit: assert property (@(posedge clk) disable iff (!rst_n)
         $countones(jrow[t] & krow[t]) <= TOG_MAX);
   end

endmodule

bind pla_mealy_seq pla_mealy_seq_chk #(
   .N_IN(N_IN), .N_ST(N_ST), .N_OUT(N_OUT),
   .N_TERM(N_TERM), .N_CMP(N_CMP), .TOG_MAX(TOG_MAX)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .cfg_wr (cfg_wr),
   .cfg_err(cfg_err),
   .st_j   (st_j),
   .st_k   (st_k),
   .out_j  (out_j),
   .out_k  (out_k),
   .lits   (lits),
   .jrow   (jrow),
   .krow   (krow),
   .feed   (feed),
   .term   (term)
);

// File: tb/pla_mealy_seq_test.sv
`timescale 1ns/1ps
module pla_mealy_seq_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [5:0]  cfg_term = '0;
   logic [1:0]  cfg_field = '0;
   logic [51:0] cfg_data = '0;
   logic        cfg_err;
   logic [15:0] in_bits = '0;
   logic [7:0]  state_q = '0;
   logic [7:0]  st_j, st_k, out_j, out_k;
   logic [31:0] ov;

   int n_chk = 0;
   int n_fail = 0;

   always #2.5 clk = ~clk;

   pla_mealy_seq uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_term(cfg_term),
      .cfg_field(cfg_field), .cfg_data(cfg_data), .cfg_err(cfg_err),
      .in_bits(in_bits), .state_q(state_q),
      .st_j(st_j), .st_k(st_k), .out_j(out_j), .out_k(out_k)
   );

   assign ov = {out_k, out_j, st_k, st_j};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input int t, input logic [1:0] f, input logic [51:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_term = t[5:0]; cfg_field = f; cfg_data = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic drive(input logic [15:0] i, input logic [7:0] s);
      @(negedge clk);
      in_bits = i; state_q = s;
      #1;
   endtask

   function automatic logic [51:0] lit1(input int v, input logic [1:0] c);
      logic [51:0] d = {52{1'b1}};
      d[2*v +: 2] = c;
      return d;
   endfunction

   function automatic logic [51:0] lit2(input int v1, input logic [1:0] c1,
                                        input int v2, input logic [1:0] c2);
      logic [51:0] d = lit1(v1, c1);
      d[2*v2 +: 2] = c2;
      return d;
   endfunction

   function automatic logic lexp(input logic [1:0] c, input logic v);
      case (c)
         2'b01:   return v;
         2'b10:   return ~v;
         2'b11:   return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   task automatic summary;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #1000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: blank image, outputs quiet for varied inputs
      chk("R1 err after reset", {31'b0, cfg_err}, 32'd0);
      for (int k = 0; k < 16; k++) begin
         drive(16'h1111 * k[15:0] ^ 16'hC35A, 8'h3B * k[7:0]);
         chk("R1 blank outputs", ov, 32'd0);
      end

      // R2: every literal code on every input/state variable, term 0 -> st_j[0]
      wr(0, 2'd1, 52'h1);
      for (int v = 0; v < 24; v++) begin
         for (int c = 0; c < 4; c++) begin
            wr(0, 2'd0, lit1(v, c[1:0]));
            for (int val = 0; val < 2; val++) begin
               logic [15:0] bi;
               logic [7:0]  bs;
               bi = 16'h5A3C; bs = 8'hC6;
               if (v < 16) bi[v] = val[0];
               else        bs[v-16] = val[0];
               drive(bi, bs);
               chk("R2 R9 literal code", {31'b0, st_j[0]}, {31'b0, lexp(c[1:0], val[0])});
            end
         end
      end
      wr(0, 2'd0, 52'h0);

      // R3: J/K bit mapping to state and output registers
      wr(1, 2'd0, lit1(4, 2'b01));
      wr(1, 2'd1, 52'h0010);
      wr(1, 2'd2, 52'h2000);
      drive(16'h0010, 8'h00);
      chk("R3 map active", ov, 32'h2000_0010);
      drive(16'h0000, 8'hFF);
      chk("R3 map inactive", ov, 32'h0000_0000);

      // R4: toggle on one register, hold elsewhere; term = in3 & ~st1
      wr(2, 2'd0, lit2(3, 2'b01, 17, 2'b10));
      wr(2, 2'd1, 52'h0004);
      wr(2, 2'd2, 52'h0004);
      for (int k = 0; k < 4; k++) begin
         drive({12'b0, k[0], 3'b0}, {6'b0, k[1], 1'b0});
         chk("R4 toggle/hold", ov, (k[0] && !k[1]) ? 32'h0000_0404 : 32'h0);
      end

      // R5: C0 fed by in0 and in1; C1 fed by in2
      wr(4, 2'd0, lit1(0, 2'b01));
      wr(4, 2'd3, 52'h1);
      wr(6, 2'd0, lit1(1, 2'b01));
      wr(6, 2'd3, 52'h1);
      wr(5, 2'd0, lit1(24, 2'b01));
      wr(5, 2'd1, 52'h0100);
      wr(7, 2'd0, lit1(2, 2'b01));
      wr(7, 2'd3, 52'h2);
      wr(8, 2'd0, lit1(25, 2'b10));
      wr(8, 2'd1, 52'h0200);
      chk("R8 accepted write clears", {31'b0, cfg_err}, 32'd0);
      for (int k = 0; k < 8; k++) begin
         logic [31:0] e;
         e = {14'b0, k[2], ~(k[0] | k[1]), 16'b0};
         drive({13'b0, k[2:0]}, 8'h00);
         chk("R5 complement arrays", ov, e);
      end

      // R6: refused feedback couplings
      wr(5, 2'd3, 52'h1);
      chk("R6 self feed refused", {31'b0, cfg_err}, 32'd1);
      drive(16'h0000, 8'h00);
      chk("R6 image kept after self feed", ov, 32'h0001_0000);
      wr(5, 2'd3, 52'h2);
      chk("R6 cross feed refused", {31'b0, cfg_err}, 32'd1);
      wr(4, 2'd0, lit2(0, 2'b01, 25, 2'b01));
      chk("R6 feeder using complement refused", {31'b0, cfg_err}, 32'd1);
      drive(16'h0005, 8'h00);
      chk("R6 image kept after feeder write", ov, 32'h0002_0000);

      // R8: flag held across idle cycles
      repeat (3) @(negedge clk);
      #1;
      chk("R8 flag held idle", {31'b0, cfg_err}, 32'd1);

      // R7: toggle fan-out limit on term 9 = in15
      wr(9, 2'd0, lit1(15, 2'b01));
      chk("R8 cleared by accepted write", {31'b0, cfg_err}, 32'd0);
      wr(9, 2'd1, 52'hFFFF);
      wr(9, 2'd2, 52'h00FF);
      chk("R7 exactly limit accepted", {31'b0, cfg_err}, 32'd0);
      drive(16'h8000, 8'h00);
      chk("R7 limit image", ov, 32'h00FF_FFFF);
      wr(9, 2'd2, 52'h01FF);
      chk("R7 over limit refused", {31'b0, cfg_err}, 32'd1);
      #1;
      chk("R7 image kept", ov, 32'h00FF_FFFF);
      wr(9, 2'd2, 52'h0FF0);
      chk("R7 shifted limit accepted", {31'b0, cfg_err}, 32'd0);
      #1;
      chk("R7 shifted image", ov, 32'h0FFF_F0FF);

      // R9: outputs follow inputs between clock edges
      @(negedge clk);
      in_bits = 16'h0000;
      #0.5;
      chk("R9 combinational follow", ov, 32'h0001_0000);

      summary();
      $finish;
   end

endmodule